// File: doc/BRIEF.md
# BCD Digit Driver for a Seven-Segment Liquid Crystal Display

This block takes one binary-coded decimal digit and produces the seven segment lines and the shared backplane line for a single liquid crystal digit. A liquid crystal cell must not see a steady DC voltage. The block therefore divides the system clock down to a square wave of about 40 Hz and places that wave on the backplane. Each segment line is the segment's on/off control bit XOR that wave.

A lit segment always sits at the opposite level to the backplane, so the cell sees an alternating voltage. A dark segment follows the backplane exactly, so its cell sees no voltage at all. Codes above nine blank the digit.

The backplane and the segment lines come from flip-flops in one clock domain, so a backplane edge and the matching segment edges fall on the same clock edge. The digit is sampled on each rising clock edge, and its pattern appears on the outputs one cycle later.

Top module: `lcd_bcd_driver`

## Requirements
- R1: The backplane starts low after reset and holds each level for exactly CLK_HZ/(2*BP_HZ) clock cycles before it toggles, which gives a 50 % duty square wave at BP_HZ (40 Hz by default).
- R2: One cycle after the digit is sampled, each segment output equals that digit's control bit XOR the backplane. In the segment vector, bit 0 is segment a and bit 6 is segment g.
- R3: Segment e (bit 4) is lit only for the digits 0, 2, 6 and 8.
- R4: The digit 6 lights segments c, d, e, f and g and leaves a and b dark (control 7'h7C).
- R5: The digit 5 lights segments a, c, d, f and g and leaves b and e dark (control 7'h6D).
- R6: The remaining decimal digits use the conventional shapes, given here as control values with bit 0 = a: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 7=7'h07, 8=7'h7F, 9=7'h6F.
- R7: The input codes 10 to 15 give control 7'h00, so every segment output equals the backplane.
- R8: While rst_n is low, the backplane and all seven segment outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit | input | 4 | BCD digit to display |
| seg | output | 7 | Segment lines; bit 0 = a through bit 6 = g |
| bp | output | 1 | Backplane square wave |

## Verification
A corrupted divider count shows at the ports as a backplane level that is held for the wrong number of cycles. The monitor compares the backplane with its own cycle count on every cycle, so a bad count is reported at the first edge that falls at the wrong place, within one half period. A wrong segment pattern, or a segment register that fails to flip together with the backplane, breaks the relation seg XOR bp = expected control. That check runs on the cycle right after each sample, so such a fault is reported at once. A reset issued in the middle of the run confirms that both the counter and the outputs restart from the low state.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int unsigned SEG_N   = 7;
    localparam int unsigned CODE_N  = 16;
    localparam int unsigned SEG_E   = 4;

    typedef logic [3:0]       bcd_t;
    typedef logic [SEG_N-1:0] seg_t;

    // Per-segment lit mask over the 16 input codes; bit k set means code k
    // lights the segment. Codes 10..15 are zero, which blanks the digit.
    localparam logic [CODE_N-1:0] LIT_MASK [SEG_N] = '{
        16'b000000_1110101101,  // a
        16'b000000_1110011111,  // b
        16'b000000_1111111011,  // c
        16'b000000_1101101101,  // d
        16'b000000_0101000101,  // e
        16'b000000_1101110001,  // f
        16'b000000_1101111100   // g
    };

    typedef struct packed {
        logic bp;
        seg_t seg;
    } drive_t;

endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == LAST) div_d.cnt = '0;
        else                   div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign wrap = (div_q.cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.cnt <= LAST); // R1

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (div_q.cnt == '0)); // R1

endmodule

// File: rtl/lcd_seg_decoder.sv
module lcd_seg_decoder
    import lcd_drv_pkg::*;
(
    input  bcd_t digit,
    output seg_t ctrl
);
    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
        assign ctrl[s] = LIT_MASK[s][digit];
    end
endmodule

// File: rtl/lcd_bcd_driver.sv
module lcd_bcd_driver
    import lcd_drv_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int unsigned BP_HZ  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] digit,
    output logic [6:0] seg,
    output logic       bp
);
    localparam int unsigned HALF = CLK_HZ / (2 * BP_HZ);

    logic   bp_wrap;
    seg_t   ctrl;
    drive_t drv_d, drv_q;

    lcd_bp_divider #(.HALF(HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (bp_wrap)
    );

    lcd_seg_decoder u_dec (
        .digit (digit),
        .ctrl  (ctrl)
    );

    always_comb begin
        drv_d     = drv_q;
        drv_d.bp  = drv_q.bp ^ bp_wrap;
        drv_d.seg = ctrl ^ {SEG_N{drv_d.bp}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign seg = drv_q.seg;
    assign bp  = drv_q.bp;

    AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bp_wrap)) |-> $stable(bp)); // R1

    AST_SEG_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((seg ^ {SEG_N{bp}}) == $past(ctrl))); // R2

    AST_E_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (seg[SEG_E] != bp)) |->
        ($past(digit) inside {4'd0, 4'd2, 4'd6, 4'd8})); // R3

    AST_BLANK_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(digit) > 4'd9)) |-> (seg == {SEG_N{bp}})); // R7

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_LOW: assert (!bp && seg == '0); // R8
        end
    end

endmodule

// File: tb/tb_lcd_bcd_driver.sv
module tb_lcd_bcd_driver;
    localparam int unsigned CLK_HZ = 1600;
    localparam int unsigned BP_HZ  = 40;
    localparam int unsigned HALF   = CLK_HZ / (2 * BP_HZ);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit = 4'd0;
    logic [6:0] seg;
    logic       bp;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    int edges = 0;

    logic [6:0] q_exp [$];
    int         q_dig [$];

    lcd_bcd_driver #(.CLK_HZ(CLK_HZ), .BP_HZ(BP_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .digit(digit), .seg(seg), .bp(bp)
    );

    always #5 clk = ~clk;

    function automatic logic [6:0] shape(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7C;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic string req_of(input int d);
        if (d > 9)  return "R7";
        if (d == 6) return "R4";
        if (d == 5) return "R5";
        return "R6";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int d, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            digit = d[3:0];
            q_exp.push_back(shape(d));
            q_dig.push_back(d);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(bp == 1'b0 && seg == 7'h00, "R8", {bp, seg}, 0);
        repeat (2) @(posedge clk);
        #1;
        check(bp == 1'b0 && seg == 7'h00, "R8", {bp, seg}, 0);
        q_exp.delete();
        q_dig.delete();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: scoreboard pop and backplane phase tracking.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) begin
                edges = 0;
            end else begin
                edges++;
                // R1: level after edge n is (n / HALF) mod 2
                check(bp == 1'(((edges / HALF) % 2)), "R1", bp, (edges / HALF) % 2);
                if (q_exp.size() > 0) begin
                    logic [6:0] e;
                    int d;
                    logic [6:0] got;
                    e = q_exp.pop_front();
                    d = q_dig.pop_front();
                    got = seg ^ {7{bp}};
                    // R2: segment = control XOR backplane
                    check(got == e, "R2", got, e);
                    check(got == e, req_of(d), got, e);
                    // R3: segment e lit only for 0, 2, 6, 8
                    check(got[4] == (d == 0 || d == 2 || d == 6 || d == 8),
                          "R3", got[4], (d == 0 || d == 2 || d == 6 || d == 8));
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(bp == 1'b0 && seg == 7'h00, "R8", {bp, seg}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int d = 0; d < 16; d++) drive(d, 3);
        drive(8, 45);
        drive(6, 45);
        for (int k = 0; k < 10; k++) begin
            drive(5, 2);
            drive(6, 1);
            drive(1, 1);
            drive(12, 1);
        end
        drive(15, 25);
        apply_reset();
        drive(2, 30);
        drive(0, 30);
        for (int d = 9; d >= 0; d--) drive(d, 1);
        @(negedge clk);
        repeat (2) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule